// File: doc/BRIEF.md
# Multiplexed External Bus Cycle Controller

This block turns single read or write requests from a processor core into complete cycles on an external bus where address and data share one set of lines. It drives an address latch strobe, a read strobe and two byte-lane write strobes. It places address or write data on the shared lines, and it sets the output enable and the transceiver direction. Every edge falls on a half-system-clock grid, so the block runs on a clock at twice the system rate. In the text below, one fast cycle equals half a system period.

A request is taken through a valid/ready handshake. `req_ready` is high only while no cycle is in progress. A request presented at any other time is held off: the core must keep `req_valid` and its fields steady until it sees ready, and nothing it drives meanwhile reaches the bus. The request carries a flag that adds an address wait state and a programmed wait count n. An external `ext_wait` input can stretch the strobe-low phase further. Completion is reported by a one-fast-cycle `rsp_valid` pulse with captured read data. This response has no back-pressure, so the core must take it in that cycle.

Top module: `mbus_cyc_ctrl`

## Requirements
- R1: While and after reset, with no request, `astb`=0, `rd_n`=`lwr_n`=`hwr_n`=1, `ad_oe`=0, `ad_dir`=0, `ad_out`=0, `rsp_valid`=0 and `req_ready`=1.
- R2: `req_ready` is 1 only when idle. A request is accepted on a rising edge with `req_valid` and `req_ready` both high. Values on the request inputs while a cycle runs change no output of that cycle, and the block is idle again in the fast cycle that follows the done pulse.
- R3: Counting fast cycles from the accepting edge, `astb` is high for 2+2a cycles, where a=1 when `req_addr_wait` was set. `ad_oe` is 1 and `ad_out` carries the address during the last 1+2a of those cycles and during the first cycle after `astb` falls. `ad_out` is 0 whenever `ad_oe` is 0.
- R4: For a read, `rd_n` falls one fast cycle after `astb` falls and stays low for 3+2n fast cycles plus any wait extension. `ad_oe` is 0 from the cycle in which `rd_n` falls until the block is idle again.
- R5: For a write, `lwr_n` goes low only when `req_be[0]`=1 and `hwr_n` goes low only when `req_be[1]`=1, with the strobe timing of R4. `rd_n` stays high. Write data is on `ad_out`, with `ad_oe`=1, from the strobe fall until one fast cycle after the strobe rises.
- R6: `ext_wait` is sampled only on the edge that would end the strobe-low phase. Each high sample extends that phase by two fast cycles, and sampling repeats at the end of each extension. At all other times the input has no effect.
- R7: In the fast cycle after the strobes rise, `astb` stays low and `rsp_valid` is 1 for exactly that cycle. For a read, `rsp_rdata` equals `ad_in` as sampled on the edge where `rd_n` rises.
- R8: `ad_dir` is 1 for every fast cycle of a write from acceptance through the done pulse. It is 1 for a read only until `rd_n` falls, and it is 0 when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the system clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core presents a request |
| req_ready | output | 1 | Block can accept a request (idle) |
| req_addr | input | AD_W | Cycle address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte lanes for writes: bit 0 low lane, bit 1 high lane |
| req_wdata | input | AD_W | Write data |
| req_addr_wait | input | 1 | Adds one system period of address phase |
| req_wait_cnt | input | WCNT_W | Programmed wait count n |
| ext_wait | input | 1 | External wait request, active high |
| ad_in | input | AD_W | Shared lines as seen from the bus |
| ad_out | output | AD_W | Value driven onto the shared lines |
| ad_oe | output | 1 | Drive enable for the shared lines |
| ad_dir | output | 1 | Transceiver direction, 1 = toward the bus |
| astb | output | 1 | Address latch strobe, active high |
| rd_n | output | 1 | Read strobe, active low |
| lwr_n | output | 1 | Low-lane write strobe, active low |
| hwr_n | output | 1 | High-lane write strobe, active low |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | AD_W | Read data captured at the read strobe rise |

## Verification
A wrong half-cycle count or a wrong state shows up within one fast cycle as a strobe edge at the wrong place or as the bus driven while a read strobe is low. Every fast cycle of every transaction is compared against a timeline built from a, n and the number of wait extensions. A mis-sampled wait input moves the strobe rise and the done pulse by two fast cycles. Wrong capture timing returns stale read data in the done cycle, and a request leaking in while busy changes `ad_out` in the same cycle.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_WAIT,
    ST_STROBE,
    ST_WAIT_EXT,
    ST_RECOVER
  } cyc_state_e;
endpackage

// File: rtl/mbus_seq.sv
module mbus_seq
  import mbus_pkg::*;
#(
  parameter int WCNT_W = 3,
  parameter int HC_W   = WCNT_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              addr_wait,
  input  logic [WCNT_W-1:0] wait_cnt,
  input  logic              ext_wait,
  output cyc_state_e        state,
  output logic [HC_W-1:0]   hc,
  output logic              capture
);
  logic              aw_q;
  logic [WCNT_W-1:0] wc_q;
  logic [HC_W-1:0]   low_last;
  cyc_state_e        state_d;
  logic [HC_W-1:0]   hc_d;

  // strobe phase: one hold half, then 3 + 2n low halves
  assign low_last = HC_W'(3) + {{(HC_W-WCNT_W-1){1'b0}}, wc_q, 1'b0};

  assign capture = !ext_wait &&
                   (((state == ST_STROBE) && (hc == low_last)) ||
                    ((state == ST_WAIT_EXT) && (hc == HC_W'(1))));

  always_comb begin
    state_d = state;
    hc_d    = hc + HC_W'(1);
    unique case (state)
      ST_IDLE: begin
        hc_d = '0;
        if (start) state_d = ST_ADDR;
      end
      ST_ADDR, ST_ADDR_WAIT: begin
        if (hc == HC_W'(1)) begin
          hc_d    = '0;
          state_d = (state == ST_ADDR && aw_q) ? ST_ADDR_WAIT : ST_STROBE;
        end
      end
      ST_STROBE: begin
        if (hc == low_last) begin
          hc_d    = '0;
          state_d = ext_wait ? ST_WAIT_EXT : ST_RECOVER;
        end
      end
      ST_WAIT_EXT: begin
        if (hc == HC_W'(1)) begin
          hc_d    = '0;
          state_d = ext_wait ? ST_WAIT_EXT : ST_RECOVER;
        end
      end
      ST_RECOVER: begin
        hc_d    = '0;
        state_d = ST_IDLE;
      end
      default: begin
        hc_d    = '0;
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      hc    <= '0;
      aw_q  <= 1'b0;
      wc_q  <= '0;
    end else begin
      state <= state_d;
      hc    <= hc_d;
      if (start) begin
        aw_q <= addr_wait;
        wc_q <= wait_cnt;
      end
    end
  end
endmodule

// File: rtl/mbus_dpath.sv
module mbus_dpath #(
  parameter int AD_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            capture,
  input  logic [AD_W-1:0] addr,
  input  logic [AD_W-1:0] wdata,
  input  logic            write,
  input  logic [1:0]      be,
  input  logic [AD_W-1:0] ad_in,
  output logic [AD_W-1:0] addr_q,
  output logic [AD_W-1:0] wdata_q,
  output logic            write_q,
  output logic [1:0]      be_q,
  output logic [AD_W-1:0] rdata_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
      be_q    <= '0;
      rdata_q <= '0;
    end else begin
      if (start) begin
        addr_q  <= addr;
        wdata_q <= wdata;
        write_q <= write;
        be_q    <= be;
      end
      if (capture && !write_q) rdata_q <= ad_in;
    end
  end
endmodule

// File: rtl/mbus_strobe_dec.sv
module mbus_strobe_dec
  import mbus_pkg::*;
#(
  parameter int AD_W = 16,
  parameter int HC_W = 5
) (
  input  cyc_state_e      state,
  input  logic [HC_W-1:0] hc,
  input  logic            write_q,
  input  logic [1:0]      be_q,
  input  logic [AD_W-1:0] addr_q,
  input  logic [AD_W-1:0] wdata_q,
  output logic            astb,
  output logic            rd_n,
  output logic            lwr_n,
  output logic            hwr_n,
  output logic            ad_oe,
  output logic            ad_dir,
  output logic [AD_W-1:0] ad_out,
  output logic            rsp_valid,
  output logic            req_ready
);
  logic low_ph, rec_ph, addr_drv, data_drv;

  assign low_ph   = ((state == ST_STROBE) && (hc != '0)) || (state == ST_WAIT_EXT);
  assign rec_ph   = (state == ST_RECOVER);
  assign addr_drv = ((state == ST_ADDR) && (hc != '0)) || (state == ST_ADDR_WAIT) ||
                    ((state == ST_STROBE) && (hc == '0));
  assign data_drv = write_q && (low_ph || rec_ph);

  assign astb      = (state == ST_ADDR) || (state == ST_ADDR_WAIT);
  assign rd_n      = !(low_ph && !write_q);
  assign lwr_n     = !(low_ph && write_q && be_q[0]);
  assign hwr_n     = !(low_ph && write_q && be_q[1]);
  assign ad_oe     = addr_drv || data_drv;
  assign ad_out    = addr_drv ? addr_q : (data_drv ? wdata_q : '0);
  assign ad_dir    = (state != ST_IDLE) && (write_q || !(low_ph || rec_ph));
  assign rsp_valid = rec_ph;
  assign req_ready = (state == ST_IDLE);
endmodule

// File: rtl/mbus_cyc_ctrl.sv
module mbus_cyc_ctrl
  import mbus_pkg::*;
#(
  parameter int AD_W   = 16,
  parameter int WCNT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AD_W-1:0]   req_addr,
  input  logic              req_write,
  input  logic [1:0]        req_be,
  input  logic [AD_W-1:0]   req_wdata,
  input  logic              req_addr_wait,
  input  logic [WCNT_W-1:0] req_wait_cnt,
  input  logic              ext_wait,
  input  logic [AD_W-1:0]   ad_in,
  output logic [AD_W-1:0]   ad_out,
  output logic              ad_oe,
  output logic              ad_dir,
  output logic              astb,
  output logic              rd_n,
  output logic              lwr_n,
  output logic              hwr_n,
  output logic              rsp_valid,
  output logic [AD_W-1:0]   rsp_rdata
);
  localparam int HC_W = WCNT_W + 2;

  cyc_state_e      state;
  logic [HC_W-1:0] hc;
  logic            capture, start;
  logic [AD_W-1:0] addr_q, wdata_q;
  logic            write_q;
  logic [1:0]      be_q;

  assign start = req_valid && req_ready;

  mbus_seq #(.WCNT_W(WCNT_W), .HC_W(HC_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .addr_wait(req_addr_wait),
    .wait_cnt(req_wait_cnt), .ext_wait(ext_wait),
    .state(state), .hc(hc), .capture(capture)
  );

  mbus_dpath #(.AD_W(AD_W)) dpath_i (
    .clk(clk), .rst_n(rst_n), .start(start), .capture(capture),
    .addr(req_addr), .wdata(req_wdata), .write(req_write), .be(req_be),
    .ad_in(ad_in), .addr_q(addr_q), .wdata_q(wdata_q), .write_q(write_q),
    .be_q(be_q), .rdata_q(rsp_rdata)
  );

  mbus_strobe_dec #(.AD_W(AD_W), .HC_W(HC_W)) dec_i (
    .state(state), .hc(hc), .write_q(write_q), .be_q(be_q),
    .addr_q(addr_q), .wdata_q(wdata_q),
    .astb(astb), .rd_n(rd_n), .lwr_n(lwr_n), .hwr_n(hwr_n),
    .ad_oe(ad_oe), .ad_dir(ad_dir), .ad_out(ad_out),
    .rsp_valid(rsp_valid), .req_ready(req_ready)
  );
endmodule

// File: rtl/mbus_cyc_ctrl_chk.sv
module mbus_cyc_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic astb,
  input logic rd_n,
  input logic lwr_n,
  input logic hwr_n,
  input logic ad_oe,
  input logic ad_dir,
  input logic rsp_valid
);
  p_no_rd_wr_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && (!lwr_n || !hwr_n)));

  p_astb_no_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    astb |-> (rd_n && lwr_n && hwr_n));

  p_read_bus_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_ready_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!astb && rd_n && lwr_n && hwr_n && !ad_oe && !rsp_valid));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_done_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_n) |-> (rsp_valid && !astb));

  p_drive_dir_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> ad_dir);
endmodule

bind mbus_cyc_ctrl mbus_cyc_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .astb(astb), .rd_n(rd_n), .lwr_n(lwr_n), .hwr_n(hwr_n),
  .ad_oe(ad_oe), .ad_dir(ad_dir), .rsp_valid(rsp_valid)
);

// File: tb/mbus_cyc_ctrl_tb_top.sv
module mbus_cyc_ctrl_tb_top;
  localparam int AD_W   = 16;
  localparam int WCNT_W = 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid, req_ready, req_write, req_addr_wait, ext_wait;
  logic [AD_W-1:0]   req_addr, req_wdata, ad_in, ad_out, rsp_rdata;
  logic [1:0]        req_be;
  logic [WCNT_W-1:0] req_wait_cnt;
  logic              ad_oe, ad_dir, astb, rd_n, lwr_n, hwr_n, rsp_valid;

  int n_run  = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  mbus_cyc_ctrl #(.AD_W(AD_W), .WCNT_W(WCNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_be(req_be),
    .req_wdata(req_wdata), .req_addr_wait(req_addr_wait),
    .req_wait_cnt(req_wait_cnt), .ext_wait(ext_wait), .ad_in(ad_in),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_dir(ad_dir), .astb(astb),
    .rd_n(rd_n), .lwr_n(lwr_n), .hwr_n(hwr_n), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // {astb, rd_n, lwr_n, hwr_n, ad_oe, rsp_valid, req_ready, ad_out}
  function automatic logic [AD_W+6:0] exp_vec(int k, int a, int n, int w, bit wr,
      logic [1:0] be, logic [AD_W-1:0] addr, logic [AD_W-1:0] wdata);
    int la, lo_last, rec;
    la      = 2 + 2*a;
    lo_last = la + 3 + 2*n + 2*w;
    rec     = lo_last + 1;
    if (k < la)
      return {1'b1, 3'b111, (k >= 1), 2'b00, (k >= 1) ? addr : {AD_W{1'b0}}};
    else if (k == la)
      return {1'b0, 3'b111, 1'b1, 2'b00, addr};
    else if (k <= lo_last)
      return {1'b0, wr, !(wr && be[0]), !(wr && be[1]), wr, 2'b00,
              wr ? wdata : {AD_W{1'b0}}};
    else if (k == rec)
      return {1'b0, 3'b111, wr, 2'b10, wr ? wdata : {AD_W{1'b0}}};
    else
      return {1'b0, 3'b111, 1'b0, 2'b01, {AD_W{1'b0}}};
  endfunction

  function automatic bit exp_dir(int k, int a, int n, int w, bit wr);
    int la, rec;
    la  = 2 + 2*a;
    rec = la + 3 + 2*n + 2*w + 1;
    if (k > rec) return 1'b0;
    if (wr) return 1'b1;
    return (k <= la);
  endfunction

  function automatic string phase_tag(int k, int a, int n, int w, bit wr);
    int la, lo_base, lo_last;
    la      = 2 + 2*a;
    lo_base = la + 3 + 2*n;
    lo_last = lo_base + 2*w;
    if (k <= la) return "R3";
    if (k <= lo_last) return (k > lo_base) ? "R6" : (wr ? "R5" : "R4");
    if (k == lo_last + 1) return "R7";
    return "R2";
  endfunction

  task automatic run_txn(input logic [AD_W-1:0] addr, input bit wr, input logic [1:0] be,
                         input logic [AD_W-1:0] wdata, input int a, input int n,
                         input int w, input bit noisy);
    int l0, rec;
    logic [AD_W-1:0] rval;
    logic [AD_W+6:0] act, exp;
    l0   = 2 + 2*a + 3 + 2*n;
    rec  = l0 + 2*w + 1;
    rval = AD_W'($urandom);
    @(negedge clk);
    req_valid     = 1'b1;
    req_addr      = addr;
    req_write     = wr;
    req_be        = be;
    req_wdata     = wdata;
    req_addr_wait = (a != 0);
    req_wait_cnt  = WCNT_W'(n);
    ext_wait      = 1'b0;
    @(posedge clk);
    for (int k = 0; k <= rec + 1; k++) begin
      @(negedge clk);
      if (k == 0) ad_in = rval;
      act = {astb, rd_n, lwr_n, hwr_n, ad_oe, rsp_valid, req_ready, ad_out};
      exp = exp_vec(k, a, n, w, wr, be, addr, wdata);
      check(act == exp, phase_tag(k, a, n, w, wr), 32'(act), 32'(exp));
      check(ad_dir == exp_dir(k, a, n, w, wr), "R8", 32'(ad_dir),
            32'(exp_dir(k, a, n, w, wr)));
      if (k == rec && !wr)
        check(rsp_rdata == rval, "R7 rdata", 32'(rsp_rdata), 32'(rval));
      // busy-time request inputs (R2)
      if (noisy && k < rec) begin
        req_valid     = 1'b1;
        req_addr      = AD_W'($urandom);
        req_wdata     = AD_W'($urandom);
        req_write     = 1'($urandom);
        req_be        = 2'($urandom);
        req_addr_wait = 1'($urandom);
        req_wait_cnt  = WCNT_W'($urandom);
      end else begin
        req_valid = 1'b0;
      end
      if (k == rec) ad_in = AD_W'($urandom);
      // wait input: high on sample points before the w-th, low on the last (R6)
      if (k >= l0 && k < l0 + 2*w) ext_wait = 1'b1;
      else if (k == l0 + 2*w)      ext_wait = 1'b0;
      else                         ext_wait = noisy ? 1'($urandom) : 1'b0;
    end
    ext_wait = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_write = 1'b0; req_be = '0;
    req_wdata = '0; req_addr_wait = 1'b0; req_wait_cnt = '0; ext_wait = 1'b0; ad_in = '0;
    @(negedge clk);
    check({astb, rd_n, lwr_n, hwr_n, ad_oe, ad_dir, rsp_valid, req_ready, ad_out} ==
          {8'b0111_0001, {AD_W{1'b0}}}, "R1 in reset",
          32'({astb, rd_n, lwr_n, hwr_n, ad_oe, ad_dir, rsp_valid, req_ready}), 32'h71);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ext_wait = 1'b1;
    repeat (2) @(negedge clk);
    check({astb, rd_n, lwr_n, hwr_n, ad_oe, ad_dir, rsp_valid, req_ready, ad_out} ==
          {8'b0111_0001, {AD_W{1'b0}}}, "R1 after reset",
          32'({astb, rd_n, lwr_n, hwr_n, ad_oe, ad_dir, rsp_valid, req_ready}), 32'h71);
    ext_wait = 1'b0;

    // directed corners
    run_txn(16'h1234, 1'b0, 2'b00, 16'h0000, 0, 0, 0, 1'b0); // R4 shortest read
    run_txn(16'hA5A5, 1'b1, 2'b11, 16'hBEEF, 1, 0, 0, 1'b0); // R3 R5 address wait, 16-bit
    run_txn(16'h0F0F, 1'b1, 2'b01, 16'h00C3, 0, 2, 0, 1'b0); // R5 low lane only
    run_txn(16'hF0F0, 1'b1, 2'b10, 16'h3C00, 0, 1, 0, 1'b0); // R5 high lane only
    run_txn(16'h5555, 1'b1, 2'b00, 16'h1111, 0, 0, 0, 1'b0); // R5 no lane
    run_txn(16'hFFFF, 1'b0, 2'b11, 16'h0000, 1, 7, 0, 1'b0); // R4 max programmed wait
    run_txn(16'h8001, 1'b0, 2'b00, 16'h0000, 0, 0, 3, 1'b0); // R6 external waits
    run_txn(16'h4002, 1'b1, 2'b11, 16'h7777, 1, 2, 1, 1'b1); // R2 R6 busy noise
    run_txn(16'h2003, 1'b0, 2'b00, 16'h0000, 0, 0, 0, 1'b1); // R2 R6 noise on read

    for (int i = 0; i < 60; i++)
      run_txn(AD_W'($urandom), 1'($urandom), 2'($urandom), AD_W'($urandom),
              int'($urandom_range(0, 1)), int'($urandom_range(0, 7)),
              int'($urandom_range(0, 3)), 1'($urandom));

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule